// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times a processor's accesses to external data memory. The processor's machine cycle has four clock states, C1 to C4. One pulse on `acc_start` begins an access. The controller then runs one or more whole machine cycles. It drives a read or a write strobe for the duration of the access. When the access ends, it returns a one-clock completion pulse to the CPU sequencer.

Two things set the length of an access:

- **Stretch count.** A programmable count gives the minimum number of machine cycles.
- **Wait input.** When a hold-off enable bit is set, an external wait pin can add any number of extra whole machine cycles.

Software can get purely pin-driven timing by setting the enable bit and a stretch count of zero. The configuration register accepts writes only when `cfg_we` is high. `cfg_we` stands for the qualifier that a protected, timed unlock sequence produces outside this block.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset, `rd_stb`, `wr_stb` and `acc_done` are low, the hold-off enable is 0 and the stretch count is 0, so the first access lasts one machine cycle whatever `ext_wait` does.
- R2: The configuration register loads `cfg_wait_en` and `cfg_stretch` only on a clock edge where `cfg_we` is 1. With `cfg_we` at 0, the values on those inputs have no effect on later accesses.
- R3: The controller accepts `acc_start` at a clock edge S when no access is running. The access then lasts T machine cycles (4·T clocks), where T = stretch + 1 plus any inserted wait cycles. Its first C1 follows edge S.
- R4: The strobe is asserted from the edge that begins C2 of the first cycle to the edge that ends C3 of the last cycle, without a gap. This spans clock edges S+1 to S+4T−2. `acc_rd`=1 at acceptance selects `rd_stb`; `acc_rd`=0 selects `wr_stb`.
- R5: `acc_done` is high for exactly one clock, during C4 of the last cycle (after edge S+4T−1). Both strobes are low in that clock.
- R6: With the hold-off enable at 0, `ext_wait` has no effect, so T = stretch + 1.
- R7: With the hold-off enable at 1, the wait input is examined in C3 of each cycle whose index is at least the stretch count. An active-high value adds one more machine cycle. The number of added cycles has no limit, and the access ends in the first such cycle that sees the input low.
- R8: With the hold-off enable at 1, the stretch count is still the minimum. A wait that is high only during cycles below that index adds nothing.
- R9: `ext_wait` passes through a two-flop synchronizer. The C3 decision of a cycle uses the pin level captured at the edge that begins C2 of that cycle. A pin that rises after that edge does not affect that cycle.
- R10: `acc_start` is ignored while an access is running.
- R11: The access captures the configuration when it is accepted. A configuration write during an access changes only later accesses.
- R12: `rd_stb` and `wr_stb` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one per machine-cycle state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write qualifier (from the timed unlock) |
| cfg_wait_en | input | 1 | Hold-off enable value to write |
| cfg_stretch | input | SW (3) | Stretch count value to write |
| acc_start | input | 1 | Request to begin an access |
| acc_rd | input | 1 | 1 = read access, 0 = write access |
| ext_wait | input | 1 | Asynchronous active-high wait pin |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| acc_done | output | 1 | One-clock completion pulse in the final C4 |

## Verification
The bench places the wait release on both sides of the C2-entry capture edge of the final cycle. A controller with one synchronizer stage too many or too few would then add a cycle or miss one.

It holds the wait pin high through the early stretched cycles. A design that honours the pin before the minimum length is reached would lengthen those accesses. It also holds the pin high with the hold-off disabled, which would expose a missing enable gate.

It writes the configuration in the middle of an access and pulses `acc_start` while the strobe is active. A controller that reads the live register, or restarts on a busy request, would change the length of the current access.

It also checks the strobe window clock by clock. This catches a strobe that drops during an inserted cycle, or a `acc_done` that comes one state early.

// File: rtl/ewsc_pkg.sv
package ewsc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_C1   = 3'd1,
        PH_C2   = 3'd2,
        PH_C3   = 3'd3,
        PH_C4   = 3'd4
    } phase_e;
endpackage

// File: rtl/ewsc_sync.sv
module ewsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ewsc_cfg.sv
module ewsc_cfg #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          wen_i,
    input  logic [SW-1:0] st_i,
    output logic          wen_o,
    output logic [SW-1:0] st_o
);
    typedef struct packed {
        logic          wen;
        logic [SW-1:0] st;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.wen = wen_i;
            cfg_d.st  = st_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign wen_o = cfg_q.wen;
    assign st_o  = cfg_q.st;
endmodule

// File: rtl/ewsc_seq.sv
module ewsc_seq
    import ewsc_pkg::*;
#(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rd_i,
    input  logic          wait_i,
    input  logic          cfg_wen_i,
    input  logic [SW-1:0] cfg_st_i,
    output logic          rd_stb_o,
    output logic          wr_stb_o,
    output logic          done_o
);
    typedef struct packed {
        phase_e        ph;
        logic [SW-1:0] cyc;
        logic [SW-1:0] st;
        logic          wen;
        logic          rd;
        logic          last;
        logic          rstb;
        logic          wstb;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;
    logic active_d;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph   = PH_C1;
                    s_d.cyc  = '0;
                    s_d.st   = cfg_st_i;
                    s_d.wen  = cfg_wen_i;
                    s_d.rd   = rd_i;
                    s_d.last = 1'b0;
                end
            end
            PH_C1: s_d.ph = PH_C2;
            PH_C2: s_d.ph = PH_C3;
            PH_C3: begin
                s_d.ph   = PH_C4;
                s_d.last = (s_q.cyc == s_q.st) && !(s_q.wen && wait_i);
            end
            PH_C4: begin
                if (s_q.last) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.ph = PH_C1;
                    if (s_q.cyc != s_q.st) s_d.cyc = s_q.cyc + 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase

        active_d = (s_d.ph == PH_C2) || (s_d.ph == PH_C3)
                || ((s_d.ph == PH_C4) && !s_d.last)
                || ((s_d.ph == PH_C1) && (s_q.ph == PH_C4));
        s_d.rstb = active_d && s_d.rd;
        s_d.wstb = active_d && !s_d.rd;
        s_d.done = (s_d.ph == PH_C4) && s_d.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_stb_o = s_q.rstb;
    assign wr_stb_o = s_q.wstb;
    assign done_o   = s_q.done;
endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl #(
    parameter int SW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_wait_en,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          acc_start,
    input  logic          acc_rd,
    input  logic          ext_wait,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          acc_done
);
    logic          wait_sync;
    logic          wen_q;
    logic [SW-1:0] st_q;

    ewsc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_wait),
        .sync_o  (wait_sync)
    );

    ewsc_cfg #(.SW(SW)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (cfg_we),
        .wen_i (cfg_wait_en),
        .st_i  (cfg_stretch),
        .wen_o (wen_q),
        .st_o  (st_q)
    );

    ewsc_seq #(.SW(SW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (acc_start),
        .rd_i      (acc_rd),
        .wait_i    (wait_sync),
        .cfg_wen_i (wen_q),
        .cfg_st_i  (st_q),
        .rd_stb_o  (rd_stb),
        .wr_stb_o  (wr_stb),
        .done_o    (acc_done)
    );
endmodule

// File: rtl/ext_wait_ctrl_chk.sv
module ext_wait_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_stb,
    input logic wr_stb,
    input logic acc_done
);
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (!rd_stb && !wr_stb));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    assert_rd_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb) |-> acc_done);

    assert_wr_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb) |-> acc_done);

    assert_done_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(rd_stb || wr_stb));

    assert_no_dir_flip_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !wr_stb);
endmodule

bind ext_wait_ctrl ext_wait_ctrl_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .acc_done (acc_done)
);

// File: tb/test_ext_wait_ctrl.sv
module test_ext_wait_ctrl;
    localparam int SW = 3;

    typedef struct packed {
        logic       rd;
        logic       en;
        logic [2:0] st;
        logic [3:0] w;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{rd:1'b1, en:1'b0, st:3'd0, w:4'd0},  // R3 R4 minimum read
        '{rd:1'b0, en:1'b0, st:3'd3, w:4'd0},  // R3 stretched write
        '{rd:1'b1, en:1'b0, st:3'd2, w:4'd5},  // R6 wait ignored
        '{rd:1'b0, en:1'b1, st:3'd0, w:4'd0},  // R7 no wait
        '{rd:1'b1, en:1'b1, st:3'd0, w:4'd1},  // R7 one wait
        '{rd:1'b0, en:1'b1, st:3'd0, w:4'd6},  // R7 many waits
        '{rd:1'b1, en:1'b1, st:3'd3, w:4'd0},  // R8 early wait ignored
        '{rd:1'b0, en:1'b1, st:3'd2, w:4'd2},  // R7 R8 mixed
        '{rd:1'b1, en:1'b1, st:3'd7, w:4'd3},  // R7 max stretch
        '{rd:1'b0, en:1'b0, st:3'd7, w:4'd9}   // R6 max stretch, wait ignored
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_wait_en = 1'b0;
    logic [SW-1:0] cfg_stretch = '0;
    logic          acc_start = 1'b0;
    logic          acc_rd = 1'b0;
    logic          ext_wait = 1'b0;
    logic          rd_stb, wr_stb, acc_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ext_wait_ctrl #(.SW(SW)) i_ext_wait_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wait_en (cfg_wait_en),
        .cfg_stretch (cfg_stretch),
        .acc_start   (acc_start),
        .acc_rd      (acc_rd),
        .ext_wait    (ext_wait),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .acc_done    (acc_done)
    );

    task automatic check1(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {rd,wr,done} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [2:0] st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wait_en = en; cfg_stretch = st;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Access accepted at edge S; j counts edges after S. Strobe expected for
    // 1 <= j <= 4T-2, done at j == 4T-1. Wait pin high at edges S+m, whi_from <= m < whi_to.
    task automatic run_acc(input string req, input logic rd, input int whi_from,
                           input int whi_to, input int exp_t, input int restart_at,
                           input int cfg_at, input logic cen, input logic [2:0] cst);
        int first_j = -1;
        logic [2:0] got_bad = '0, exp_bad = '0;
        @(negedge clk);
        acc_start = 1'b1;
        acc_rd    = rd;
        ext_wait  = (whi_from <= 0) && (0 < whi_to);
        for (int j = 0; j <= 4*exp_t + 2; j++) begin
            logic es, ed;
            logic [2:0] g, e;
            @(negedge clk);
            es = (j >= 1) && (j <= 4*exp_t - 2);
            ed = (j == 4*exp_t - 1);
            g  = {rd_stb, wr_stb, acc_done};
            e  = {es && rd, es && !rd, ed};
            if (g !== e && first_j < 0) begin
                first_j = j; got_bad = g; exp_bad = e;
            end
            acc_start   = (j + 1 == restart_at);
            acc_rd      = ~rd;
            ext_wait    = (whi_from <= j + 1) && (j + 1 < whi_to);
            cfg_we      = (j + 1 == cfg_at);
            cfg_wait_en = cen;
            cfg_stretch = cst;
        end
        acc_start = 1'b0; ext_wait = 1'b0; cfg_we = 1'b0;
        n_chk++;
        if (first_j >= 0) begin
            n_bad++;
            $display("FAIL %s: edge S+%0d {rd,wr,done} got %b expected %b (T=%0d)",
                     req, first_j, got_bad, exp_bad, exp_t);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check1("R1 in reset", {rd_stb, wr_stb, acc_done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1 after reset", {rd_stb, wr_stb, acc_done}, 3'b000);
        // R1: reset config en=0 st=0 -> one cycle despite wait held high
        run_acc("R1 reset config", 1'b1, 0, 40, 1, -1, -1, 1'b0, 3'd0);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int t;
            write_cfg(VECS[v].en, VECS[v].st);
            t = int'(VECS[v].st) + 1 + (VECS[v].en ? int'(VECS[v].w) : 0);
            run_acc($sformatf("R3-vector%0d", v), VECS[v].rd, 0,
                    4*(int'(VECS[v].st) + int'(VECS[v].w)) + 1, t, -1, -1, 1'b0, 3'd0);
        end

        // R9 boundary: wait high only at the C2-entry edge of cycle 0 -> one extra cycle
        write_cfg(1'b1, 3'd0);
        run_acc("R9 captured at C2 entry", 1'b0, 1, 2, 2, -1, -1, 1'b0, 3'd0);
        // R9 boundary: wait rises one edge later -> not seen
        run_acc("R9 too late", 1'b1, 2, 60, 1, -1, -1, 1'b0, 3'd0);

        // R10: start pulsed mid access is ignored
        write_cfg(1'b0, 3'd1);
        run_acc("R10 busy start", 1'b0, 0, 0, 2, 3, -1, 1'b0, 3'd0);

        // R11: config write mid access affects only the next access
        run_acc("R11 current access", 1'b1, 0, 0, 2, -1, 4, 1'b0, 3'd3);
        run_acc("R11 next access", 1'b1, 0, 0, 4, -1, -1, 1'b0, 3'd0);

        // R2: data on config inputs without cfg_we is ignored
        @(negedge clk);
        cfg_we = 1'b0; cfg_wait_en = 1'b1; cfg_stretch = 3'd6;
        repeat (2) @(negedge clk);
        run_acc("R2 no write enable", 1'b0, 0, 60, 4, -1, -1, 1'b0, 3'd0);

        // R12 idle quiet after all activity
        repeat (2) @(negedge clk);
        check1("R12 idle", {rd_stb, wr_stb, acc_done}, 3'b000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule